// File: doc/BRIEF.md
# Serial Byte Transmitter with Direction Enables and Clear-to-Send Gating

This block turns bytes from a valid/ready handshake into asynchronous serial frames on a single output line: one start bit, eight data bits sent least significant bit first, one stop bit, and no parity. The line rests high. A clock divider, set by a parameter, fixes the number of system clocks in each bit period.

There are two modes, selected by a mode input that is captured when each byte is accepted. In shared-bus mode the block drives two enable outputs for an external differential transceiver. Both go high for the whole time a frame is in progress and low otherwise. In this mode the clear-to-send input is ignored. In point-to-point mode both enables stay low and a clear-to-send input controls the flow. That input passes through a two-flop synchronizer and is checked only when a new byte would start. A high level holds the next byte back. A byte that has already started always runs to its end and is never sent again. Holding clear-to-send low for good gives an unthrottled link.

Each frame opens with one bit period of idle-high lead-in, so that the enables are raised before the start bit. The frame closes when the stop bit has run its full length.

Top module: `uart_flow_tx`

## Requirements
- R1: After reset the serial line is high, both enables and the busy flag are low, and, with clear-to-send low, the input handshake shows ready.
- R2: An accepted byte produces, one bit period each (CLKS_PER_BIT clocks): a high lead-in bit, a low start bit, the data bits with bit 0 first, then a high stop bit.
- R3: In shared-bus mode (mode input = 1) the enables drvEn and rxDis are both high from the clock edge that accepts the byte until the end of its stop bit. At all other times they are both low.
- R4: In point-to-point mode (mode input = 0) both enables stay low throughout.
- R5: In point-to-point mode a synchronized high clear-to-send keeps ready low, so no byte is accepted and the line stays idle high.
- R6: A rise of clear-to-send while a frame is in progress does not alter or shorten that frame.
- R7: After a frame during which clear-to-send rose, the next byte waits until clear-to-send falls. The frame that follows carries the next byte and does not repeat the earlier one.
- R8: In shared-bus mode clear-to-send has no effect, and bytes are accepted and sent while it is high.
- R9: Ready is high only while no frame is in progress. A byte is taken on a clock edge where both valid and ready are high, and busy is high from that edge to the end of the stop bit.
- R10: The mode is captured at acceptance. Changing the mode input during a frame does not change that frame's enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeHalf | input | 1 | 1 = shared-bus mode with enables, 0 = point-to-point mode with clear-to-send |
| ctsIn | input | 1 | Clear-to-send, asynchronous; high holds the next byte back |
| inData | input | DATA_W | Byte to send |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block takes the byte on this edge if inValid is high |
| txLine | output | 1 | Serial output, idles high |
| drvEn | output | 1 | Transceiver driver enable |
| rxDis | output | 1 | Transceiver receiver disable, same level as drvEn |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with CLKS_PER_BIT = 6 in place of the default of 16. This keeps each frame at 66 clocks, so a run can cover dozens of frames in both modes. It also places every bit centre on a whole clock. With the shorter bit period, a clear-to-send rise and a mode flip can each be placed on a chosen data bit of a frame, and long stalls with clear-to-send high can be observed across many bit times.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;   // capture a new byte into the shifter
    logic shift;  // advance the shifter by one bit
  } txStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txState_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R2
  baud_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeHalf,
  input  logic       ctsIn,
  input  logic       inValid,
  input  logic       tick,
  output logic       inReady,
  output logic       busy,
  output logic       enActive,
  output txStrobes_t strobes
);
  // lead-in + start + data + stop
  localparam int FRAME_TICKS = DATA_W + 3;
  localparam int BW = $clog2(FRAME_TICKS + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_TICKS - 1);

  txState_e      state;
  logic [BW-1:0] bitCnt;
  logic          ctsMeta, ctsSync;
  logic          modeReg;
  logic          accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b0;
      ctsSync <= 1'b0;
    end else begin
      ctsMeta <= ctsIn;
      ctsSync <= ctsMeta;
    end
  end

  assign inReady = (state == ST_IDLE) && (modeHalf || !ctsSync);
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      modeReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_SEND;
          bitCnt  <= '0;
          modeReg <= modeHalf;
        end
        ST_SEND: if (tick) begin
          if (bitCnt == LAST_BIT) state <= ST_IDLE;
          bitCnt <= bitCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state == ST_SEND);
  assign enActive      = busy && modeReg;
  assign strobes.load  = accept;
  assign strobes.shift = busy && tick;

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !busy);

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= LAST_BIT));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(modeReg));
endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] inData,
  output logic              txLine
);
  localparam int SR_W = DATA_W + 3;

  logic [SR_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '1;
    else if (strobes.load)   shiftReg <= {1'b1, inData, 1'b0, 1'b1};
    else if (strobes.shift)  shiftReg <= {1'b1, shiftReg[SR_W-1:1]};
  end

  assign txLine = shiftReg[0];

  // R2
  lead_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> txLine);
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeHalf,
  input  logic              ctsIn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              txLine,
  output logic              drvEn,
  output logic              rxDis,
  output logic              busy
);
  txStrobes_t strobes;
  logic       tick;
  logic       enActive;

  uart_tx_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_baud (
    .clk  (clk),
    .rstN (rstN),
    .clr  (strobes.load),
    .tick (tick)
  );

  uart_tx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeHalf (modeHalf),
    .ctsIn    (ctsIn),
    .inValid  (inValid),
    .tick     (tick),
    .inReady  (inReady),
    .busy     (busy),
    .enActive (enActive),
    .strobes  (strobes)
  );

  uart_tx_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .txLine  (txLine)
  );

  assign drvEn = enActive;
  assign rxDis = enActive;

  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R3
  enable_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> busy);
endmodule

// File: tb/test_uart_flow_tx.sv
module test_uart_flow_tx;
  localparam int N = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeHalf = 1'b0;
  logic ctsIn = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, txLine, drvEn, rxDis, busy;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_flow_tx #(.DATA_W(DW), .CLKS_PER_BIT(N)) i_uart_flow_tx (
    .clk(clk), .rstN(rstN), .modeHalf(modeHalf), .ctsIn(ctsIn),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .txLine(txLine), .drvEn(drvEn), .rxDis(rxDis), .busy(busy)
  );

  function automatic logic frameBit(logic [DW-1:0] d, int j);
    if (j == 0) return 1'b0;
    if (j == DW + 1) return 1'b1;
    return d[j-1];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Present a byte, wait for acceptance, then check the whole frame.
  task automatic sendAndCheck(logic [DW-1:0] d, logic half,
                              int ctsRiseBit, int modeFlipBit);
    modeHalf = half;
    inData = d;
    inValid = 1'b1;
    forever begin
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    // R9 busy from acceptance; R2 lead-in high; R3/R4 enables
    chk(busy === 1'b1, "R9", busy, 1);
    chk(txLine === 1'b1, "R2", txLine, 1);
    chk(drvEn === half && rxDis === half, "R3", drvEn, half);
    for (int j = 0; j <= DW + 1; j++) begin
      int w;
      w = (j == 0) ? N + N / 2 : N;
      for (int k = 0; k < w; k++) @(negedge clk);
      if (j == ctsRiseBit) ctsIn = 1'b1;
      if (j == modeFlipBit) modeHalf = ~half;
      // R2 bit value (R6 when CTS rose mid-frame)
      chk(txLine === frameBit(d, j), (ctsRiseBit >= 0) ? "R6" : "R2",
          txLine, frameBit(d, j));
      // R3/R4/R10 enables keep the mode captured at acceptance
      chk(drvEn === half && rxDis === half,
          (modeFlipBit >= 0) ? "R10" : (half ? "R3" : "R4"), drvEn, half);
      chk(busy === 1'b1, "R9", busy, 1);
    end
    for (int k = 0; k < N / 2; k++) @(negedge clk);
    chk(busy === 1'b0, "R9", busy, 0);
    chk(drvEn === 1'b0 && rxDis === 1'b0, "R3", drvEn, 0);
    chk(txLine === 1'b1, "R2", txLine, 1);
  endtask

  initial begin
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txLine === 1'b1, "R1", txLine, 1);
    chk(drvEn === 1'b0 && rxDis === 1'b0, "R1", drvEn, 0);
    chk(busy === 1'b0, "R1", busy, 0);
    chk(inReady === 1'b1, "R1", inReady, 1);

    // Directed frames
    sendAndCheck(8'hA5, 1'b1, -1, -1);
    sendAndCheck(8'h01, 1'b0, -1, -1);
    sendAndCheck(8'h80, 1'b1, -1, -1);
    sendAndCheck(8'h00, 1'b0, -1, -1);
    sendAndCheck(8'hFF, 1'b1, -1, -1);

    // R5: CTS high in point-to-point mode blocks acceptance
    modeHalf = 1'b0;
    ctsIn = 1'b1;
    repeat (4) @(negedge clk);
    inData = 8'h3C;
    inValid = 1'b1;
    begin
      bit held = 1;
      for (int k = 0; k < 5 * N; k++) begin
        @(negedge clk);
        if (inReady !== 1'b0 || busy !== 1'b0 || txLine !== 1'b1) held = 0;
      end
      chk(held, "R5", held, 1);
    end
    ctsIn = 1'b0;
    repeat (3) @(negedge clk);
    sendAndCheck(8'h3C, 1'b0, -1, -1);

    // R6 / R7: CTS rises during data bit 4, frame completes; next byte waits
    sendAndCheck(8'hC3, 1'b0, 4, -1);
    inData = 8'h5A;
    inValid = 1'b1;
    begin
      bit held = 1;
      for (int k = 0; k < 6 * N; k++) begin
        @(negedge clk);
        if (inReady !== 1'b0 || busy !== 1'b0 || txLine !== 1'b1) held = 0;
      end
      chk(held, "R7", held, 1);
    end
    ctsIn = 1'b0;
    // R7 next frame carries 0x5A, not a resend of 0xC3
    sendAndCheck(8'h5A, 1'b0, -1, -1);

    // R8: shared-bus mode ignores CTS
    ctsIn = 1'b1;
    repeat (4) @(negedge clk);
    modeHalf = 1'b1;
    @(negedge clk);
    chk(inReady === 1'b1, "R8", inReady, 1);
    sendAndCheck(8'h96, 1'b1, -1, -1);
    ctsIn = 1'b0;
    repeat (3) @(negedge clk);

    // R10: mode flips mid-frame, enables follow captured mode
    sendAndCheck(8'h69, 1'b1, -1, 3);
    sendAndCheck(8'h17, 1'b0, -1, 5);

    // Random frames, CTS low
    for (int i = 0; i < 24; i++) begin
      logic [DW-1:0] d;
      logic h;
      d = DW'($urandom);
      h = 1'($urandom);
      sendAndCheck(d, h, -1, -1);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule